// File: doc/BRIEF.md
# Dual-Port Block Memory with Per-Port Aspect Ratio

This block models an 18K-bit true dual-port memory. Port A and port B each have their own clock, active-low reset, clock enable, 3-bit select input, write enable, 14-bit address bus and 18-bit data buses. Each port is configured on its own at elaboration time. The configuration sets the data width (1, 2, 4, 9 or 18 bits), what the output shows while the port writes, whether an output register adds a second cycle of latency, and which select value the port answers to. Widths other than the five listed are rejected at elaboration. Read-before-write below 9 bits is also rejected at elaboration.

Both ports view one shared storage array, so a word written at one width can be read back through the other port at another width. Storage is organised as 1024 rows of 18 bits. Each row holds two 9-bit bytes. The 9- and 18-bit widths use every bit. The 1-, 2- and 4-bit widths see only the low eight bits of each byte, which gives 16 data bits per row. The memory powers up to zero, and reset does not clear it.

The caller keeps the two ports apart. Two writes to one location in the same cycle are not allowed. A write on one port while the other port reads the same location is also not allowed. The ports carry no back-pressure: every accepted request is served, and the caller times its reads by the configured latency.

Top module: `dpr_mem`

## Requirements
- R1: After reset both `dout` buses read zero. Memory contents written before the reset can still be read after it.
- R2: With the output register off, the result of a request accepted at clock edge k appears on `dout` after edge k.
- R3: With the output register on, the result of a request accepted at edge k appears on `dout` after edge k+1, and `dout` keeps its earlier value between those two edges.
- R4: A request whose `sel` differs from the port's configured select value is ignored: memory does not change and an unregistered `dout` holds its value.
- R5: While `ce` is low, the port accepts no request, memory does not change, and `dout` holds its value, including the value in the output register.
- R6: In write-through mode (mode code 1), an accepted write puts the new data, cut to the port width, on `dout` with the port's normal latency.
- R7: In read-before-write mode (mode code 2, legal only at 9 and 18 bits), an accepted write shows the location's previous contents on `dout`.
- R8: In normal mode (mode code 0), `dout` keeps its previous value across an accepted write.
- R9: Data bits at and above the port width are ignored on write and read as zero on `dout`. Address bits at and above the port's address width (14, 13, 12, 11 or 10 bits for widths 1, 2, 4, 9 or 18) are ignored.
- R10: Data bit j of word N at width W sits at global storage bit N*W+j for W of 9 or 18. For narrower W, set L = N*W+j; the bit then sits at (L/8)*9 + L%8. A port reads back whatever the other port wrote at those bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| rst_a_n | input | 1 | Port A asynchronous reset, active low |
| ce_a | input | 1 | Port A clock enable |
| sel_a | input | 3 | Port A select, compared with the configured value |
| we_a | input | 1 | Port A write enable |
| addr_a | input | 14 | Port A address, low bits used |
| din_a | input | 18 | Port A write data, low bits used |
| dout_a | output | 18 | Port A read data, zero above the port width |
| clk_b | input | 1 | Port B clock |
| rst_b_n | input | 1 | Port B asynchronous reset, active low |
| ce_b | input | 1 | Port B clock enable |
| sel_b | input | 3 | Port B select, compared with the configured value |
| we_b | input | 1 | Port B write enable |
| addr_b | input | 14 | Port B address, low bits used |
| din_b | input | 18 | Port B write data, low bits used |
| dout_b | output | 18 | Port B read data, zero above the port width |

## Verification
A bad storage bit stays hidden until some port reads that location. It then shows as a wrong value on `dout` one cycle later, or two cycles later when the output register is on. For that reason the bench writes every location and then reads every location back through the port of the other width. A wrong lane offset or row index does not fail at one address only. It shows as bytes swapped, or as nibbles landing on the unused ninth bit, across a whole sweep. A fault in the latch or in the output-register gating shows at once: `dout` moves on a cycle where it should hold, or lags one edge behind its expected value.

// File: rtl/dpr_pkg.sv
package dpr_pkg;

  localparam int BUS_AW    = 14;
  localparam int BUS_DW    = 18;
  localparam int SEL_W     = 3;
  localparam int ROW_DW    = 18;
  localparam int ROWS      = 1024;
  localparam int ROW_AW    = $clog2(ROWS);
  localparam int LSB_W     = $clog2(ROW_DW);
  localparam int LANE_DW   = ROW_DW / 2;
  localparam int LANE_DATA = 8;
  localparam int ROW_DATA  = 2 * LANE_DATA;
  localparam int ROW_SHIFT = $clog2(ROW_DATA);

  typedef enum logic [1:0] {
    WM_NORMAL  = 2'd0,
    WM_THROUGH = 2'd1,
    WM_BEFORE  = 2'd2
  } wmode_e;

  function automatic int addr_bits(input int w);
    case (w)
      1:       return 14;
      2:       return 13;
      4:       return 12;
      9:       return 11;
      18:      return 10;
      default: return 0;
    endcase
  endfunction

  function automatic bit width_ok(input int w);
    return addr_bits(w) != 0;
  endfunction

  function automatic bit mode_ok(input int w, input wmode_e m);
    return (m != WM_BEFORE) || (w >= LANE_DW);
  endfunction

endpackage

// File: rtl/dpr_lane.sv
module dpr_lane
  import dpr_pkg::*;
#(
  parameter int W = 18
) (
  input  logic [BUS_AW-1:0] addr,
  input  logic [BUS_DW-1:0] din,
  input  logic [ROW_DW-1:0] row_mix,
  output logic [ROW_AW-1:0] row_idx,
  output logic [ROW_DW-1:0] wmask,
  output logic [ROW_DW-1:0] wplace,
  output logic [ROW_DW-1:0] rd_val
);

  localparam int AW = addr_bits(W);
  localparam logic [ROW_DW-1:0] LOWM = ROW_DW'((64'd1 << W) - 64'd1);

  logic [LSB_W-1:0] lsb;
  logic             unused_addr;

  assign unused_addr = ^addr;

  generate
    if (W == ROW_DW) begin : g_full
      assign row_idx = addr[ROW_AW-1:0];
      assign lsb     = '0;
    end else if (W == LANE_DW) begin : g_half
      assign row_idx = addr[ROW_AW:1];
      assign lsb     = addr[0] ? LSB_W'(LANE_DW) : '0;
    end else begin : g_narrow
      localparam int LOGW = $clog2(W);
      logic [BUS_AW-1:0] lin;
      assign lin     = BUS_AW'(addr[AW-1:0]) << LOGW;
      assign row_idx = lin[BUS_AW-1:ROW_SHIFT];
      assign lsb     = (lin[ROW_SHIFT-1] ? LSB_W'(LANE_DW) : '0)
                     + LSB_W'(lin[ROW_SHIFT-2:0]);
    end
  endgenerate

  assign wmask  = LOWM << lsb;
  assign wplace = (din & LOWM) << lsb;
  assign rd_val = (row_mix >> lsb) & LOWM;

endmodule

// File: rtl/dpr_bank.sv
module dpr_bank #(
  parameter int DEPTH = 1024,
  parameter int DW    = 18,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wrow,
  input  logic [DW-1:0] flip,
  input  logic [AW-1:0] rrow0,
  input  logic [AW-1:0] rrow1,
  output logic [DW-1:0] rdat0,
  output logic [DW-1:0] rdat1
);

  logic [DW-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
  end

  always_ff @(posedge clk) begin
    if (we) mem[wrow] <= mem[wrow] ^ flip;
  end

  assign rdat0 = mem[rrow0];
  assign rdat1 = mem[rrow1];

endmodule

// File: rtl/dpr_port.sv
module dpr_port
  import dpr_pkg::*;
#(
  parameter int               W      = 18,
  parameter wmode_e           MODE   = WM_NORMAL,
  parameter bit               REGOUT = 1'b0,
  parameter logic [SEL_W-1:0] CS     = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce,
  input  logic [SEL_W-1:0]  sel,
  input  logic              we,
  input  logic [BUS_AW-1:0] addr,
  input  logic [BUS_DW-1:0] din,
  input  logic [ROW_DW-1:0] row_mix,
  output logic [ROW_AW-1:0] row_idx,
  output logic              wr_en,
  output logic [ROW_DW-1:0] wr_flip,
  output logic [BUS_DW-1:0] dout
);

  localparam logic [ROW_DW-1:0] LOWM = ROW_DW'((64'd1 << W) - 64'd1);

  generate
    if (!width_ok(W)) begin : g_bad_width
      $error("dpr_port: width %0d is not one of 1, 2, 4, 9, 18", W);
    end
    if (!mode_ok(W, MODE)) begin : g_bad_mode
      $error("dpr_port: read-before-write needs width 9 or 18, got %0d", W);
    end
  endgenerate

  logic [ROW_DW-1:0] wmask, wplace, rd_val;
  logic              accept;
  logic [BUS_DW-1:0] lat_q;

  dpr_lane #(.W(W)) u_lane (
    .addr   (addr),
    .din    (din),
    .row_mix(row_mix),
    .row_idx(row_idx),
    .wmask  (wmask),
    .wplace (wplace),
    .rd_val (rd_val)
  );

  assign accept  = ce && (sel == CS);
  assign wr_en   = accept && we;
  assign wr_flip = (row_mix ^ wplace) & wmask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q <= '0;
    end else if (accept) begin
      if (!we) begin
        lat_q <= rd_val;
      end else begin
        case (MODE)
          WM_THROUGH: lat_q <= din & LOWM;
          WM_BEFORE:  lat_q <= rd_val;
          default:    lat_q <= lat_q;
        endcase
      end
    end
  end

  generate
    if (REGOUT) begin : g_outreg
      logic [BUS_DW-1:0] out_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  out_q <= '0;
        else if (ce) out_q <= lat_q;
      end
      assign dout = out_q;
    end else begin : g_direct
      assign dout = lat_q;
    end
  endgenerate

endmodule

// File: rtl/dpr_mem.sv
module dpr_mem
  import dpr_pkg::*;
#(
  parameter int               A_WIDTH  = 9,
  parameter wmode_e           A_MODE   = WM_BEFORE,
  parameter bit               A_REGOUT = 1'b0,
  parameter logic [SEL_W-1:0] A_CS     = 3'd5,
  parameter int               B_WIDTH  = 4,
  parameter wmode_e           B_MODE   = WM_THROUGH,
  parameter bit               B_REGOUT = 1'b1,
  parameter logic [SEL_W-1:0] B_CS     = 3'd2
) (
  input  logic        clk_a,
  input  logic        rst_a_n,
  input  logic        ce_a,
  input  logic [2:0]  sel_a,
  input  logic        we_a,
  input  logic [13:0] addr_a,
  input  logic [17:0] din_a,
  output logic [17:0] dout_a,
  input  logic        clk_b,
  input  logic        rst_b_n,
  input  logic        ce_b,
  input  logic [2:0]  sel_b,
  input  logic        we_b,
  input  logic [13:0] addr_b,
  input  logic [17:0] din_b,
  output logic [17:0] dout_b
);

  localparam int NPORT = 2;

  logic              bclk  [NPORT];
  logic              bwe   [NPORT];
  logic [ROW_AW-1:0] brow  [NPORT];
  logic [ROW_DW-1:0] bflip [NPORT];
  logic [ROW_DW-1:0] bq    [NPORT][NPORT];
  logic [ROW_DW-1:0] mix   [NPORT];

  assign bclk[0] = clk_a;
  assign bclk[1] = clk_b;

  genvar k;
  generate
    for (k = 0; k < NPORT; k++) begin : g_bank
      dpr_bank #(.DEPTH(ROWS), .DW(ROW_DW)) u_bank (
        .clk  (bclk[k]),
        .we   (bwe[k]),
        .wrow (brow[k]),
        .flip (bflip[k]),
        .rrow0(brow[0]),
        .rrow1(brow[1]),
        .rdat0(bq[k][0]),
        .rdat1(bq[k][1])
      );
      assign mix[k] = bq[0][k] ^ bq[1][k];
    end
  endgenerate

  dpr_port #(.W(A_WIDTH), .MODE(A_MODE), .REGOUT(A_REGOUT), .CS(A_CS)) u_pa (
    .clk    (clk_a),
    .rst_n  (rst_a_n),
    .ce     (ce_a),
    .sel    (sel_a),
    .we     (we_a),
    .addr   (addr_a),
    .din    (din_a),
    .row_mix(mix[0]),
    .row_idx(brow[0]),
    .wr_en  (bwe[0]),
    .wr_flip(bflip[0]),
    .dout   (dout_a)
  );

  dpr_port #(.W(B_WIDTH), .MODE(B_MODE), .REGOUT(B_REGOUT), .CS(B_CS)) u_pb (
    .clk    (clk_b),
    .rst_n  (rst_b_n),
    .ce     (ce_b),
    .sel    (sel_b),
    .we     (we_b),
    .addr   (addr_b),
    .din    (din_b),
    .row_mix(mix[1]),
    .row_idx(brow[1]),
    .wr_en  (bwe[1]),
    .wr_flip(bflip[1]),
    .dout   (dout_b)
  );

endmodule

// File: rtl/dpr_mem_chk.sv
module dpr_mem_chk
  import dpr_pkg::*;
#(
  parameter int               A_WIDTH  = 9,
  parameter wmode_e           A_MODE   = WM_BEFORE,
  parameter bit               A_REGOUT = 1'b0,
  parameter logic [SEL_W-1:0] A_CS     = 3'd5,
  parameter int               B_WIDTH  = 4,
  parameter wmode_e           B_MODE   = WM_THROUGH,
  parameter bit               B_REGOUT = 1'b1,
  parameter logic [SEL_W-1:0] B_CS     = 3'd2
) (
  input logic        clk_a,
  input logic        rst_a_n,
  input logic        ce_a,
  input logic [2:0]  sel_a,
  input logic        we_a,
  input logic [17:0] din_a,
  input logic [17:0] dout_a,
  input logic        clk_b,
  input logic        rst_b_n,
  input logic        ce_b,
  input logic [2:0]  sel_b,
  input logic        we_b,
  input logic [17:0] din_b,
  input logic [17:0] dout_b
);

  localparam logic [17:0] A_LOW = 18'((64'd1 << A_WIDTH) - 64'd1);
  localparam logic [17:0] B_LOW = 18'((64'd1 << B_WIDTH) - 64'd1);

  logic unused_chk;
  assign unused_chk = ^{din_a, din_b, we_a, we_b, sel_a, sel_b};

  // R5
  a_ce_hold_chk: assert property (@(posedge clk_a) disable iff (!rst_a_n)
    !ce_a |=> $stable(dout_a));

  // R5
  b_ce_hold_chk: assert property (@(posedge clk_b) disable iff (!rst_b_n)
    !ce_b |=> $stable(dout_b));

  generate
    if (!A_REGOUT) begin : g_a_direct
      // R4
      a_cs_miss_chk: assert property (@(posedge clk_a) disable iff (!rst_a_n)
        (ce_a && sel_a != A_CS) |=> $stable(dout_a));
      if (A_MODE == WM_NORMAL) begin : g_norm
        // R8
        a_normal_hold_chk: assert property (@(posedge clk_a) disable iff (!rst_a_n)
          (ce_a && sel_a == A_CS && we_a) |=> $stable(dout_a));
      end
      if (A_MODE == WM_THROUGH) begin : g_thru
        // R6
        a_through_chk: assert property (@(posedge clk_a) disable iff (!rst_a_n)
          (ce_a && sel_a == A_CS && we_a) |=> dout_a == ($past(din_a) & A_LOW));
      end
    end
    if (!B_REGOUT) begin : g_b_direct
      // R4
      b_cs_miss_chk: assert property (@(posedge clk_b) disable iff (!rst_b_n)
        (ce_b && sel_b != B_CS) |=> $stable(dout_b));
      if (B_MODE == WM_NORMAL) begin : g_norm
        // R8
        b_normal_hold_chk: assert property (@(posedge clk_b) disable iff (!rst_b_n)
          (ce_b && sel_b == B_CS && we_b) |=> $stable(dout_b));
      end
      if (B_MODE == WM_THROUGH) begin : g_thru
        // R6
        b_through_chk: assert property (@(posedge clk_b) disable iff (!rst_b_n)
          (ce_b && sel_b == B_CS && we_b) |=> dout_b == ($past(din_b) & B_LOW));
      end
    end
    if (A_WIDTH < 18) begin : g_a_upper
      // R9
      a_upper_zero_chk: assert property (@(posedge clk_a) disable iff (!rst_a_n)
        (dout_a & ~A_LOW) == '0);
    end
    if (B_WIDTH < 18) begin : g_b_upper
      // R9
      b_upper_zero_chk: assert property (@(posedge clk_b) disable iff (!rst_b_n)
        (dout_b & ~B_LOW) == '0);
    end
  endgenerate

endmodule

bind dpr_mem dpr_mem_chk #(
  .A_WIDTH(A_WIDTH), .A_MODE(A_MODE), .A_REGOUT(A_REGOUT), .A_CS(A_CS),
  .B_WIDTH(B_WIDTH), .B_MODE(B_MODE), .B_REGOUT(B_REGOUT), .B_CS(B_CS)
) u_chk (
  .clk_a(clk_a), .rst_a_n(rst_a_n), .ce_a(ce_a), .sel_a(sel_a), .we_a(we_a),
  .din_a(din_a), .dout_a(dout_a),
  .clk_b(clk_b), .rst_b_n(rst_b_n), .ce_b(ce_b), .sel_b(sel_b), .we_b(we_b),
  .din_b(din_b), .dout_b(dout_b)
);

// File: tb/sim_dpr_mem.sv
module sim_dpr_mem;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  int n_tests = 0;
  int n_fail  = 0;

  // u0: A 9-bit read-before-write direct sel 5; B 4-bit write-through registered sel 2
  logic        ce0a = 1'b1, we0a = 1'b0, ce0b = 1'b1, we0b = 1'b0;
  logic [2:0]  sel0a = 3'd2, sel0b = 3'd5;
  logic [13:0] ad0a = '0, ad0b = '0;
  logic [17:0] di0a = '0, di0b = '0;
  logic [17:0] do0a, do0b;

  // u1: A 18-bit normal direct sel 0; B 1-bit write-through direct sel 7
  logic        ce1a = 1'b1, we1a = 1'b0, ce1b = 1'b1, we1b = 1'b0;
  logic [2:0]  sel1a = 3'd7, sel1b = 3'd0;
  logic [13:0] ad1a = '0, ad1b = '0;
  logic [17:0] di1a = '0, di1b = '0;
  logic [17:0] do1a, do1b;

  dpr_mem u0 (
    .clk_a(clk), .rst_a_n(rst_n), .ce_a(ce0a), .sel_a(sel0a), .we_a(we0a),
    .addr_a(ad0a), .din_a(di0a), .dout_a(do0a),
    .clk_b(clk), .rst_b_n(rst_n), .ce_b(ce0b), .sel_b(sel0b), .we_b(we0b),
    .addr_b(ad0b), .din_b(di0b), .dout_b(do0b)
  );

  dpr_mem #(
    .A_WIDTH(18), .A_MODE(dpr_pkg::WM_NORMAL),  .A_REGOUT(1'b0), .A_CS(3'd0),
    .B_WIDTH(1),  .B_MODE(dpr_pkg::WM_THROUGH), .B_REGOUT(1'b0), .B_CS(3'd7)
  ) u1 (
    .clk_a(clk), .rst_a_n(rst_n), .ce_a(ce1a), .sel_a(sel1a), .we_a(we1a),
    .addr_a(ad1a), .din_a(di1a), .dout_a(do1a),
    .clk_b(clk), .rst_b_n(rst_n), .ce_b(ce1b), .sel_b(sel1b), .we_b(we1b),
    .addr_b(ad1b), .din_b(di1b), .dout_b(do1b)
  );

  logic [17:0] m0 [1024];
  logic [17:0] m1 [1024];

  function automatic int phys(input int w, input int a, input int j);
    int l;
    if (w >= 9) return a * w + j;
    l = a * w + j;
    return (l / 8) * 9 + (l % 8);
  endfunction

  function automatic logic [17:0] mread(input int inst, input int w, input int a);
    logic [17:0] v;
    v = '0;
    for (int j = 0; j < w; j++) begin
      int p;
      p = phys(w, a, j);
      v[j] = (inst == 0) ? m0[p / 18][p % 18] : m1[p / 18][p % 18];
    end
    return v;
  endfunction

  task automatic mwrite(input int inst, input int w, input int a, input logic [17:0] d);
    for (int j = 0; j < w; j++) begin
      int p;
      p = phys(w, a, j);
      if (inst == 0) m0[p / 18][p % 18] = d[j];
      else           m1[p / 18][p % 18] = d[j];
    end
  endtask

  task automatic chk(input string tag, input logic [17:0] act, input logic [17:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic op0a(input logic we, input int a, input logic [17:0] d,
                      input logic [2:0] sel, input logic ce);
    ce0a = ce; sel0a = sel; we0a = we; ad0a = a[13:0]; di0a = d;
    @(negedge clk);
    ce0a = 1'b1; sel0a = 3'd2; we0a = 1'b0;
  endtask

  task automatic op0b(input logic we, input int a, input logic [17:0] d,
                      input logic [2:0] sel, input logic ce);
    ce0b = ce; sel0b = sel; we0b = we; ad0b = a[13:0]; di0b = d;
    @(negedge clk);
    ce0b = 1'b1; sel0b = 3'd5; we0b = 1'b0;
  endtask

  task automatic op1a(input logic we, input int a, input logic [17:0] d);
    ce1a = 1'b1; sel1a = 3'd0; we1a = we; ad1a = a[13:0]; di1a = d;
    @(negedge clk);
    sel1a = 3'd7; we1a = 1'b0;
  endtask

  task automatic op1b(input logic we, input int a, input logic [17:0] d);
    ce1b = 1'b1; sel1b = 3'd7; we1b = we; ad1b = a[13:0]; di1b = d;
    @(negedge clk);
    sel1b = 3'd0; we1b = 1'b0;
  endtask

  initial begin
    #(4 * 150000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [17:0] last_b, last_a1, prev, e;
    for (int i = 0; i < 1024; i++) begin m0[i] = '0; m1[i] = '0; end
    repeat (3) @(negedge clk);
    chk("R1 reset dout u0a", do0a, '0);
    chk("R1 reset dout u0b", do0b, '0);
    chk("R1 reset dout u1a", do1a, '0);
    chk("R1 reset dout u1b", do1b, '0);
    rst_n = 1'b1;
    @(negedge clk);

    // R7: first write pass, old contents are zero; upper data bits must be dropped (R9)
    for (int a = 0; a < 2048; a++) begin
      e = 18'((a * 37 + 11) % 512);
      op0a(1'b1, a, {9'h1AB, e[8:0]}, 3'd5, 1'b1);
      chk("R7 first pass old value", do0a, mread(0, 9, a));
      mwrite(0, 9, a, e);
    end

    // R10 / R3: read every nibble through the 4-bit registered port
    last_b = '0;
    for (int n = 0; n < 4096; n++) begin
      op0b(1'b0, n, '0, 3'd2, 1'b1);
      chk("R3 registered output lags", do0b, last_b);
      @(negedge clk);
      e = mread(0, 4, n);
      chk("R10 nibble view of 9-bit writes", do0b, e);
      last_b = e;
    end

    // R7 / R2: second pass returns first-pass contents
    for (int a = 0; a < 2048; a++) begin
      e = 18'((a * 101 + 300) % 512);
      op0a(1'b1, a, e, 3'd5, 1'b1);
      chk("R7 second pass old value", do0a, mread(0, 9, a));
      mwrite(0, 9, a, e);
    end

    // R6 / R9: write-through on the 4-bit port with all upper data bits set
    for (int n = 0; n < 16; n++) begin
      e = 18'(n ^ 9);
      op0b(1'b1, n, {14'h3FFF, e[3:0]}, 3'd2, 1'b1);
      chk("R3 write result lags", do0b, last_b);
      @(negedge clk);
      chk("R6 R9 write-through data", do0b, e);
      mwrite(0, 4, n, e);
      last_b = e;
    end
    for (int a = 0; a < 8; a++) begin
      op0a(1'b0, a, '0, 3'd5, 1'b1);
      chk("R10 9-bit view of nibble writes", do0a, mread(0, 9, a));
    end

    // R9: address bits above the 9-bit port's 11 are ignored
    op0a(1'b0, 14'h3800 | 14'd5, '0, 3'd5, 1'b1);
    chk("R9 upper address ignored", do0a, mread(0, 9, 5));
    prev = do0a;

    // R4: select mismatch
    op0a(1'b1, 7, 18'h055, 3'd4, 1'b1);
    chk("R4 sel mismatch holds dout", do0a, prev);
    op0a(1'b0, 7, '0, 3'd5, 1'b1);
    chk("R4 sel mismatch leaves memory", do0a, mread(0, 9, 7));
    prev = do0a;

    // R5: clock enable low on the direct port
    op0a(1'b1, 9, 18'h0AA, 3'd5, 1'b0);
    chk("R5 ce low holds dout", do0a, prev);
    op0a(1'b0, 9, '0, 3'd5, 1'b1);
    chk("R5 ce low leaves memory", do0a, mread(0, 9, 9));

    // R5: clock enable low freezes the output register
    op0b(1'b1, 3, 18'h0000C, 3'd2, 1'b1);
    mwrite(0, 4, 3, 18'h0000C);
    ce0b = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R5 ce low holds output register", do0b, last_b);
    ce0b = 1'b1;
    @(negedge clk);
    chk("R5 output register resumes", do0b, 18'h0000C);

    // R1: reset clears outputs, keeps memory
    rst_n = 1'b0;
    #1;
    chk("R1 mid-run reset dout u0a", do0a, '0);
    chk("R1 mid-run reset dout u0b", do0b, '0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    op0a(1'b0, 5, '0, 3'd5, 1'b1);
    chk("R1 memory kept over reset (A)", do0a, mread(0, 9, 5));
    op0b(1'b0, 3, '0, 3'd2, 1'b1);
    @(negedge clk);
    chk("R1 memory kept over reset (B)", do0b, 18'h0000C);

    // R8 / R2: normal mode on the 18-bit port
    last_a1 = '0;
    for (int r = 0; r < 64; r++) begin
      e = 18'((r * 12345 + 777) % 262144);
      op1a(1'b1, r, e);
      chk("R8 normal write holds dout", do1a, last_a1);
      mwrite(1, 18, r, e);
      op1a(1'b0, r, '0);
      chk("R2 direct read latency", do1a, e);
      last_a1 = e;
    end

    // R10: 1-bit view skips the ninth bit of each byte
    for (int l = 0; l < 1024; l++) begin
      op1b(1'b0, l, '0);
      chk("R10 single-bit view", do1b, mread(1, 1, l));
    end

    // R6 / R9 on the 1-bit port, then cross-check through the 18-bit port
    op1b(1'b1, 8, 18'h3FFFF);
    mwrite(1, 1, 8, 18'h1);
    chk("R6 R9 one-bit write-through", do1b, 18'h1);
    op1a(1'b0, 0, '0);
    chk("R10 18-bit view of one-bit write", do1a, mread(1, 18, 0));

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule